// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Buffer

This block holds the outgoing data of one bulk or interrupt IN endpoint in two equal halves of 64 bytes each. The CPU side loads bytes into whichever half it currently owns, then commits that half by writing a byte count. Ownership of the half then passes to the bus side, and the CPU goes on to load the other half. The bus side empties committed halves in the order they were committed, so the CPU can load one half while the bus side sends from the other.

The bus side is modelled as a simple token and handshake exchange. A one-cycle `in_req` asks for a packet. When no committed half is waiting, the block answers with a one-cycle `nak` and sends no data. When a half is waiting, the block streams its bytes one per cycle and then waits for the host's verdict. `hs_ack` frees the half. `hs_timeout` keeps it, so the same bytes go out again on the next request. A `buf_avail` level tells the CPU that a half is free to load, and `avail_irq` pulses when that level returns. A bus reset hands both halves back to the CPU. Packet encoding, CRC and line signalling belong to other blocks.

Top module: `dbuf_in_ep`

## Requirements
- R1: After `rst`, `buf_avail` is 1 and `avail_irq`, `nak`, `tx_valid`, `tx_last` and `tx_zlp` are all 0.
- R2: Bytes written with `cpu_wr` fill the CPU half in write order. Once the half is committed with count N (1 to 64), a request that the block samples at clock edge k produces N beats with `tx_valid` high on consecutive cycles, the first one registered at edge k+1. `tx_last` is high on the Nth beat only, and halves go out in the order they were committed.
- R3: A request that arrives while no half is committed produces `nak` high for exactly one cycle, registered at the sampling edge, with no `tx_valid` beat.
- R4: A commit with count 0 produces a single beat on which `tx_valid`, `tx_last` and `tx_zlp` are all high.
- R5: `buf_avail` is 0 exactly while both halves are committed and not yet acknowledged.
- R6: While both halves are committed, `cpu_wr` and `cpu_commit` have no effect, and the data already committed goes out unchanged.
- R7: `hs_timeout` after a packet keeps the half committed, and the next request sends the same bytes again.
- R8: `hs_ack` after a packet frees the half. When this raises `buf_avail` from 0 to 1, `avail_irq` is high for one cycle.
- R9: A one-cycle `usb_reset` returns both halves to the CPU. `buf_avail` is 1 from the next cycle, `avail_irq` pulses if `buf_avail` was 0, and the next request receives `nak`.
- R10: A request that arrives while a packet is still being sent, or is waiting for its handshake, is ignored: it produces neither `nak` nor data.
- R11: Writes beyond the 64th byte of a half are dropped.
- R12: A commit and an `hs_ack` in the same cycle both take effect. The number of committed halves does not change, and the newly committed half is sent on the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write one byte into the CPU half |
| cpu_wdata | input | 8 | Byte to write |
| cpu_commit | input | 1 | Commit the CPU half with `cpu_count` |
| cpu_count | input | 7 | Packet length, 0 to 64 |
| buf_avail | output | 1 | A half is free for the CPU |
| avail_irq | output | 1 | One-cycle pulse when `buf_avail` rises |
| usb_reset | input | 1 | Bus reset, returns both halves to the CPU |
| in_req | input | 1 | Host asks for a packet |
| hs_ack | input | 1 | Host acknowledged the last packet |
| hs_timeout | input | 1 | Host did not acknowledge the last packet |
| nak | output | 1 | No data ready for this request |
| tx_valid | output | 1 | Data beat valid |
| tx_data | output | 8 | Data byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_zlp | output | 1 | Beat stands for a zero-length packet |

## Verification
Two events can meet in a single cycle: the CPU commits a freshly loaded half in the same cycle that the host acknowledges the half being sent. The bench creates this by loading the second half while the first one is in flight, then driving `cpu_commit` and `hs_ack` on the same edge. The outcome is judged at the ports. `buf_avail` must stay high because exactly one half remains committed, the next request must return the new packet, and the request after that must be answered with NAK.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/dbuf_ram.sv
module dbuf_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // write port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbuf_owner.sv
module dbuf_owner #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic             cpu_wr,
  input  logic             cpu_commit,
  input  logic [CNT_W-1:0] cpu_count,
  input  logic             tx_ack,
  output logic             mem_we,
  output logic [PTR_W:0]   mem_waddr,
  output logic             bus_idx,
  output logic [CNT_W-1:0] bus_len,
  output logic             have_data,
  output logic             buf_avail,
  output logic             avail_irq
);
  logic [1:0]       n_q, n_next;
  logic             cpu_idx_q, bus_idx_q;
  logic [CNT_W-1:0] wptr_q;
  logic [CNT_W-1:0] len_q [2];
  logic [CNT_W-1:0] cnt_c;
  logic             room, take, give;

  assign room  = (n_q != 2'd2);
  assign take  = cpu_commit && room && !bus_rst;
  assign give  = tx_ack && (n_q != 2'd0) && !bus_rst;
  assign cnt_c = (cpu_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cpu_count;

  always_comb begin
    if (bus_rst) n_next = 2'd0;
    else         n_next = n_q + {1'b0, take} - {1'b0, give};
  end

  assign mem_we    = cpu_wr && room && !bus_rst && (wptr_q != CNT_W'(DEPTH));
  assign mem_waddr = {cpu_idx_q, wptr_q[PTR_W-1:0]};
  assign bus_idx   = bus_idx_q;
  assign bus_len   = len_q[bus_idx_q];
  assign have_data = (n_q != 2'd0);

  // ownership bookkeeping: which half each side holds and how many are committed
  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      n_q       <= 2'd0;
      cpu_idx_q <= 1'b0;
      bus_idx_q <= 1'b0;
      wptr_q    <= '0;
    end else begin
      n_q <= n_next;
      if (take) begin
        len_q[cpu_idx_q] <= cnt_c;
        cpu_idx_q        <= ~cpu_idx_q;
        wptr_q           <= '0;
      end else if (mem_we) begin
        wptr_q <= wptr_q + CNT_W'(1);
      end
      if (give) bus_idx_q <= ~bus_idx_q;
    end
  end

  // availability flag and its rising-edge interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_avail <= 1'b1;
      avail_irq <= 1'b0;
    end else begin
      buf_avail <= (n_next != 2'd2);
      avail_irq <= (n_next != 2'd2) && !buf_avail;
    end
  end
endmodule

// File: rtl/dbuf_tx.sv
module dbuf_tx
  import dbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic             in_req,
  input  logic             hs_ack,
  input  logic             hs_timeout,
  input  logic             have_data,
  input  logic             bus_idx,
  input  logic [CNT_W-1:0] bus_len,
  output logic [PTR_W:0]   rd_addr,
  output logic             tx_ack,
  output logic             nak,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             tx_zlp
);
  tx_state_e        st_q;
  logic [CNT_W-1:0] ptr_q;
  logic             at_end;

  assign rd_addr = {bus_idx, ptr_q[PTR_W-1:0]};
  assign at_end  = (ptr_q == bus_len - CNT_W'(1));
  assign tx_ack  = (st_q == TX_WAIT) && hs_ack;

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      st_q     <= TX_IDLE;
      ptr_q    <= '0;
      nak      <= 1'b0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      tx_zlp   <= 1'b0;
    end else begin
      nak      <= 1'b0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      tx_zlp   <= 1'b0;
      unique case (st_q)
        TX_IDLE: begin
          if (in_req) begin
            if (have_data) begin
              st_q  <= TX_SEND;
              ptr_q <= '0;
            end else begin
              nak <= 1'b1;
            end
          end
        end
        TX_SEND: begin
          tx_valid <= 1'b1;
          if (bus_len == '0) begin
            tx_last <= 1'b1;
            tx_zlp  <= 1'b1;
            st_q    <= TX_WAIT;
          end else begin
            tx_last <= at_end;
            ptr_q   <= ptr_q + CNT_W'(1);
            if (at_end) st_q <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (hs_ack || hs_timeout) st_q <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbuf_in_ep.sv
module dbuf_in_ep #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_commit,
  input  logic [CNT_W-1:0]  cpu_count,
  output logic              buf_avail,
  output logic              avail_irq,
  input  logic              usb_reset,
  input  logic              in_req,
  input  logic              hs_ack,
  input  logic              hs_timeout,
  output logic              nak,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_zlp
);
  logic             mem_we, bus_idx, have_data, tx_ack;
  logic [PTR_W:0]   mem_waddr, rd_addr;
  logic [CNT_W-1:0] bus_len;

  dbuf_owner #(.DEPTH(DEPTH)) u_owner (
    .clk(clk), .rst(rst), .bus_rst(usb_reset),
    .cpu_wr(cpu_wr), .cpu_commit(cpu_commit), .cpu_count(cpu_count),
    .tx_ack(tx_ack), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .bus_idx(bus_idx), .bus_len(bus_len), .have_data(have_data),
    .buf_avail(buf_avail), .avail_irq(avail_irq)
  );

  dbuf_tx #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .bus_rst(usb_reset),
    .in_req(in_req), .hs_ack(hs_ack), .hs_timeout(hs_timeout),
    .have_data(have_data), .bus_idx(bus_idx), .bus_len(bus_len),
    .rd_addr(rd_addr), .tx_ack(tx_ack), .nak(nak),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_zlp(tx_zlp)
  );

  dbuf_ram #(.DATA_W(DATA_W), .ADDR_W(PTR_W + 1)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(cpu_wdata),
    .raddr(rd_addr), .rdata(tx_data)
  );
endmodule

// File: rtl/dbuf_in_ep_chk.sv
module dbuf_in_ep_chk (
  input logic clk,
  input logic rst,
  input logic usb_reset,
  input logic in_req,
  input logic nak,
  input logic tx_valid,
  input logic tx_last,
  input logic tx_zlp,
  input logic buf_avail,
  input logic avail_irq
);
  // R3
  nak_excl_chk: assert property (@(posedge clk) disable iff (rst) nak |-> !tx_valid);

  // R3
  nak_cause_chk: assert property (@(posedge clk) disable iff (rst) nak |-> $past(in_req));

  // R4
  zlp_shape_chk: assert property (@(posedge clk) disable iff (rst) tx_zlp |-> (tx_valid && tx_last));

  // R2
  beat_run_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_last && !usb_reset) |=> tx_valid);

  // R8
  irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    avail_irq |-> (buf_avail && !$past(buf_avail)));

  // R9
  reset_free_chk: assert property (@(posedge clk) disable iff (rst) usb_reset |=> buf_avail);
endmodule

bind dbuf_in_ep dbuf_in_ep_chk u_chk (
  .clk(clk), .rst(rst), .usb_reset(usb_reset), .in_req(in_req),
  .nak(nak), .tx_valid(tx_valid), .tx_last(tx_last), .tx_zlp(tx_zlp),
  .buf_avail(buf_avail), .avail_irq(avail_irq)
);

// File: tb/sim_dbuf_in_ep.sv
`timescale 1ns/1ps
module sim_dbuf_in_ep;
  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_wr = 0, cpu_commit = 0, usb_reset = 0, in_req = 0, hs_ack = 0, hs_timeout = 0;
  logic [7:0] cpu_wdata = '0;
  logic [CNT_W-1:0] cpu_count = '0;
  logic buf_avail, avail_irq, nak, tx_valid, tx_last, tx_zlp;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  dbuf_in_ep #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_commit(cpu_commit), .cpu_count(cpu_count), .buf_avail(buf_avail),
    .avail_irq(avail_irq), .usb_reset(usb_reset), .in_req(in_req),
    .hs_ack(hs_ack), .hs_timeout(hs_timeout), .nak(nak), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp)
  );

  int checks = 0, errors = 0, irq_cnt = 0, base = 0;
  bit done = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected bus items: {nak, zlp, last, data}
  task automatic push_pkt(int seed, int len, string tag);
    if (len == 0) begin
      exp_q.push_back({1'b0, 1'b1, 1'b1, 8'h00}); tag_q.push_back(tag);
    end else begin
      for (int i = 0; i < len; i++) begin
        exp_q.push_back({1'b0, 1'b0, (i == len - 1), pat(seed, i)});
        tag_q.push_back(tag);
      end
    end
  endtask

  always @(posedge clk) if (!rst && avail_irq) irq_cnt++;

  // monitor: every nak or data beat is popped and compared
  always @(negedge clk) begin
    logic [10:0] got, want;
    string t;
    if (!rst && (nak || tx_valid)) begin
      got = {nak, tx_zlp, tx_last, (nak || tx_zlp) ? 8'h00 : tx_data};
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected bus beat: actual %0h expected none", got);
      end else begin
        want = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == want, t, "bus beat", int'(got), int'(want));
      end
    end
  end

  task automatic write_pkt(int seed, int nw, int cnt, bit commit);
    for (int i = 0; i < nw; i++) begin
      cpu_wr = 1; cpu_wdata = pat(seed, i);
      @(negedge clk);
    end
    cpu_wr = 0;
    if (commit) begin
      cpu_commit = 1; cpu_count = CNT_W'(cnt);
      @(negedge clk);
      cpu_commit = 0;
    end
  endtask

  task automatic req_nak(string tag);
    exp_q.push_back({1'b1, 1'b0, 1'b0, 8'h00}); tag_q.push_back(tag);
    in_req = 1; @(negedge clk); in_req = 0;
    check(nak == 1, tag, "nak after request", nak, 1);
    @(negedge clk);
    check(tx_valid == 0, tag, "no data for empty endpoint", tx_valid, 0);
  endtask

  task automatic req_data(int seed, int len, bit ack, bit poke, string tag,
                          bit commit_too = 0, int ccnt = 0);
    push_pkt(seed, len, tag);
    in_req = 1; @(negedge clk); in_req = 0;
    check(nak == 0 && tx_valid == 0, tag, "quiet one cycle after request", {nak, tx_valid}, 0);
    @(negedge clk);
    check(tx_valid == 1, "R2", "first beat latency", tx_valid, 1);
    while (!tx_last) @(negedge clk);
    if (poke) begin
      in_req = 1; @(negedge clk); in_req = 0; @(negedge clk);
    end
    hs_ack = ack; hs_timeout = !ack;
    if (commit_too) begin cpu_commit = 1; cpu_count = CNT_W'(ccnt); end
    @(negedge clk);
    hs_ack = 0; hs_timeout = 0; cpu_commit = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check(buf_avail == 1 && avail_irq == 0, "R1", "avail/irq after reset", {buf_avail, avail_irq}, 2);
    check(nak == 0 && tx_valid == 0 && tx_last == 0 && tx_zlp == 0, "R1", "bus outputs after reset",
          {nak, tx_valid, tx_last, tx_zlp}, 0);
    req_nak("R3");

    write_pkt(1, 5, 5, 1);
    check(buf_avail == 1, "R5", "avail with one half committed", buf_avail, 1);
    write_pkt(2, 64, 64, 1);
    check(buf_avail == 0, "R5", "avail with both halves committed", buf_avail, 0);
    base = irq_cnt;
    write_pkt(3, 10, 3, 1);
    check(buf_avail == 0, "R6", "avail after ignored commit", buf_avail, 0);

    req_data(1, 5, 0, 0, "R7");
    check(buf_avail == 0, "R7", "avail after timeout", buf_avail, 0);
    req_data(1, 5, 1, 1, "R7");
    check(buf_avail == 1, "R8", "avail after ack", buf_avail, 1);
    @(negedge clk);
    check(irq_cnt == base + 1, "R8", "irq pulses", irq_cnt, base + 1);

    req_data(2, 64, 1, 0, "R6");
    req_nak("R3");

    write_pkt(4, 0, 0, 1);
    req_data(4, 0, 1, 0, "R4");

    // R12: commit and ack in the same cycle
    write_pkt(5, 8, 8, 1);
    write_pkt(6, 6, 0, 0);
    req_data(5, 8, 1, 0, "R12", 1, 6);
    check(buf_avail == 1, "R12", "avail after commit with ack", buf_avail, 1);
    req_data(6, 6, 1, 0, "R12");
    req_nak("R12");

    write_pkt(7, 70, 64, 1);
    req_data(7, 64, 1, 0, "R11");

    // R9: bus reset with both halves committed
    write_pkt(8, 4, 4, 1);
    write_pkt(9, 4, 4, 1);
    check(buf_avail == 0, "R9", "full before bus reset", buf_avail, 0);
    base = irq_cnt;
    usb_reset = 1; @(negedge clk); usb_reset = 0;
    check(buf_avail == 1, "R9", "avail after bus reset", buf_avail, 1);
    @(negedge clk);
    check(irq_cnt == base + 1, "R9", "irq after bus reset", irq_cnt, base + 1);
    req_nak("R9");
    write_pkt(10, 3, 3, 1);
    req_data(10, 3, 1, 0, "R9");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all expected beats seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule